// File: doc/BRIEF.md
# Word-to-Halfword Read Bridge

This block sits between a processor read port that asks for 8-, 16- or 32-bit data and a backing store that is physically only 16 bits wide (32K halfwords, 64 KB). A 32-bit read becomes two back-to-back halfword accesses. The first access reads the lower halfword at halfword address A and the second reads the upper halfword at A+1. The two are joined in little-endian order, so the byte at the lowest address ends up in the least significant lane. Halfword and byte reads need one access. For a byte read the correct lane is selected and zero-extended.

The processor side uses a ready/valid handshake. A request is taken only while the bridge is idle. The bridge latches the request when it takes it. The answer comes back as a one-cycle data-valid pulse. The memory side is a plain synchronous read port: an enable and a halfword address in one cycle, and the read data in the next. A 32-bit read whose address is not word aligned issues no access and answers with an alignment-error flag.

Top module: `halfword_fetch_bridge`

## Requirements
- R1: While reset is asserted and right after it is released, `reqReady` is 1 and `rspValid`, `rspAlignErr`, `memEn` and `rspData` are all 0.
- R2: A request is taken in a cycle where `reqValid` and `reqReady` are both 1 (the accept cycle). `reqReady` is 1 only when idle. It stays 0 from the cycle after acceptance through the `rspValid` cycle, and returns to 1 in the cycle after `rspValid`.
- R3: A word read (`reqSize` 2 or 3, address bits [1:0] = 0) makes exactly two memory accesses. The first is in the accept cycle at `reqAddr[15:1]` and the second is in the next cycle at that address + 1. `rspData` is {second halfword, first halfword}, and `rspValid` is high three cycles after the accept cycle.
- R4: A halfword read (`reqSize` = 1) makes one access in the accept cycle at `reqAddr[15:1]`. Address bit 0 is ignored. `rspData` is the halfword zero-extended to 32 bits, and `rspValid` is high two cycles after the accept cycle.
- R5: A byte read (`reqSize` = 0) makes one access at `reqAddr[15:1]`. `rspData[7:0]` is bits [7:0] of the halfword when address bit 0 is 0 and bits [15:8] when it is 1. Bits [31:8] are 0, and timing is the same as R4.
- R6: A word read with address bits [1:0] not 0 makes no memory access. `rspValid` and `rspAlignErr` are both high one cycle after the accept cycle, and `rspData` is 0.
- R7: `rspValid` lasts exactly one cycle. While `rspValid` is 0, `rspData` is 0 and `rspAlignErr` is 0. `rspAlignErr` is 0 for every aligned request.
- R8: `memEn` is high only in the accept cycle of a non-faulting request and, for a word read, in the cycle after it. It is never high while `rspValid` is high.
- R9: The request inputs are sampled only in the accept cycle. Changing `reqAddr` or `reqSize` after acceptance does not change the accesses or the response.

Size encoding: `reqSize` 0 = byte, 1 = halfword, 2 or 3 = word (bit 1 set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Processor read request present |
| reqAddr | input | 16 | Byte address of the read |
| reqSize | input | 2 | 0 byte, 1 halfword, 2/3 word |
| reqReady | output | 1 | Bridge idle, request can be taken |
| rspValid | output | 1 | One-cycle response strobe |
| rspData | output | 32 | Response data, zero when not valid |
| rspAlignErr | output | 1 | Misaligned word read, with rspValid |
| memEn | output | 1 | Memory read enable |
| memAddr | output | 15 | Memory halfword address |
| memRdata | input | 16 | Memory read data, one cycle after memEn |

## Verification
If the sequencer lands in a wrong state, the fault shows at the ports within a few cycles. It can appear as a missing or extra `memEn` pulse, as `rspValid` coming one cycle early or late, or as `reqReady` rising while a request is still open. A wrong halfword register or a wrong second address shows up as a bad upper or lower half in `rspData` in the response cycle. A wrong lane choice or wrong zero-extension shows up in that same cycle. The bench's memory returns data that depends on the address, so a wrong address cannot hide behind matching data.

// File: rtl/hwb_pkg.sv
package hwb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_RESP = 2'd3
  } bridgeState_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;     // latch request fields
    logic secondAcc;   // drive upper-halfword address
    logic loadLow;     // hold the lower halfword
    logic loadNarrow;  // load a byte/halfword response
    logic loadWord;    // load a joined word response
    logic loadErr;     // load an alignment-error response
    logic clrRsp;      // clear response registers
  } bridgeStrobe_t;

endpackage

// File: rtl/hwb_ctrl.sv
module hwb_ctrl
  import hwb_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqWide,
  input  logic          reqMisalign,
  output logic          reqReady,
  output logic          memEn,
  output logic          rspValid,
  output bridgeStrobe_t strobe
);

  bridgeState_t state, stateNext;
  logic wordReq;
  logic idle, accept;

  assign idle   = (state == ST_IDLE);
  assign accept = idle && reqValid;

  always_comb begin
    strobe            = '0;
    strobe.capture    = accept;
    strobe.loadErr    = accept && reqMisalign;
    strobe.secondAcc  = (state == ST_LOW);
    strobe.loadLow    = (state == ST_LOW) && wordReq;
    strobe.loadNarrow = (state == ST_LOW) && !wordReq;
    strobe.loadWord   = (state == ST_HIGH);
    strobe.clrRsp     = (state == ST_RESP);
  end

  assign reqReady = idle;
  assign rspValid = (state == ST_RESP);
  assign memEn    = (accept && !reqMisalign) || ((state == ST_LOW) && wordReq);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (accept) stateNext = reqMisalign ? ST_RESP : ST_LOW;
      ST_LOW:  stateNext = wordReq ? ST_HIGH : ST_RESP;
      ST_HIGH: stateNext = ST_RESP;
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordReq <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept) wordReq <= reqWide;
    end
  end

endmodule

// File: rtl/hwb_datapath.sv
module hwb_datapath
  import hwb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bridgeStrobe_t         strobe,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [1:0]            reqSize,
  input  logic [HALF_W-1:0]     memRdata,
  output logic [ADDR_W-2:0]     memAddr,
  output logic [2*HALF_W-1:0]   rspData,
  output logic                  rspAlignErr,
  output logic                  reqWide,
  output logic                  reqMisalign
);

  localparam int HW_ADDR_W = ADDR_W - 1;
  localparam int WORD_W    = 2 * HALF_W;
  localparam int BYTE_W    = HALF_W / 2;

  logic [HW_ADDR_W-1:0] capAddr;
  logic                 capLane;
  logic                 capByte;
  logic [HALF_W-1:0]    lowHalf;
  logic [WORD_W-1:0]    narrowVal;
  logic [BYTE_W-1:0]    laneByte;

  assign reqWide     = reqSize[1];
  assign reqMisalign = reqSize[1] && (reqAddr[1:0] != 2'b00);

  // The upper half of an aligned word sits at an odd halfword address.
  assign memAddr = strobe.secondAcc ? {capAddr[HW_ADDR_W-1:1], 1'b1}
                                    : reqAddr[ADDR_W-1:1];

  assign laneByte  = capLane ? memRdata[HALF_W-1:BYTE_W] : memRdata[BYTE_W-1:0];
  assign narrowVal = capByte ? {{(WORD_W-BYTE_W){1'b0}}, laneByte}
                             : {{(WORD_W-HALF_W){1'b0}}, memRdata};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAddr <= '0;
      capLane <= 1'b0;
      capByte <= 1'b0;
    end else if (strobe.capture) begin
      capAddr <= reqAddr[ADDR_W-1:1];
      capLane <= reqAddr[0];
      capByte <= (reqSize == SZ_BYTE);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lowHalf <= '0;
    else if (strobe.loadLow) lowHalf <= memRdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspData     <= '0;
      rspAlignErr <= 1'b0;
    end else if (strobe.clrRsp) begin
      rspData     <= '0;
      rspAlignErr <= 1'b0;
    end else if (strobe.loadErr) begin
      rspData     <= '0;
      rspAlignErr <= 1'b1;
    end else if (strobe.loadNarrow) begin
      rspData     <= narrowVal;
      rspAlignErr <= 1'b0;
    end else if (strobe.loadWord) begin
      rspData     <= {memRdata, lowHalf};
      rspAlignErr <= 1'b0;
    end
  end

endmodule

// File: rtl/halfword_fetch_bridge.sv
module halfword_fetch_bridge
  import hwb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [1:0]          reqSize,
  output logic                reqReady,
  output logic                rspValid,
  output logic [2*HALF_W-1:0] rspData,
  output logic                rspAlignErr,
  output logic                memEn,
  output logic [ADDR_W-2:0]   memAddr,
  input  logic [HALF_W-1:0]   memRdata
);

  bridgeStrobe_t strobe;
  logic reqWide, reqMisalign;

  hwb_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqWide     (reqWide),
    .reqMisalign (reqMisalign),
    .reqReady    (reqReady),
    .memEn       (memEn),
    .rspValid    (rspValid),
    .strobe      (strobe)
  );

  hwb_datapath #(
    .ADDR_W (ADDR_W),
    .HALF_W (HALF_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .reqSize     (reqSize),
    .memRdata    (memRdata),
    .memAddr     (memAddr),
    .rspData     (rspData),
    .rspAlignErr (rspAlignErr),
    .reqWide     (reqWide),
    .reqMisalign (reqMisalign)
  );

endmodule

// File: rtl/halfword_fetch_bridge_checker.sv
module halfword_fetch_bridge_checker #(
  parameter int ADDR_W = 16,
  parameter int HALF_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic [ADDR_W-1:0]   reqAddr,
  input logic [1:0]          reqSize,
  input logic                reqReady,
  input logic                rspValid,
  input logic [2*HALF_W-1:0] rspData,
  input logic                rspAlignErr,
  input logic                memEn,
  input logic [ADDR_W-2:0]   memAddr
);

  localparam logic [ADDR_W-2:0] HW_ONE = 1;

  logic badWord;
  assign badWord = reqSize[1] && (reqAddr[1:0] != 2'b00);

  // R1: outputs held at their reset values while reset is asserted
  always @(posedge clk) begin
    if (!rstN) begin
      a_r1_reset_outputs: assert (!rspValid && !rspAlignErr && (rspData == '0) && reqReady)
        else $error("R1 outputs not at reset values");
    end
  end

  // R2: after acceptance the bridge is busy
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R3: a second access in a row targets the next halfword
  a_r3_second_addr: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !reqReady) |-> ($past(memEn) && (memAddr == $past(memAddr) + HW_ONE)));

  // R6: a misaligned word issues no access and answers with the error flag
  a_r6_no_access: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && badWord) |-> !memEn);
  a_r6_err_next: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && badWord) |=> (rspValid && rspAlignErr));

  // R7: response strobe is a single cycle, outputs quiet otherwise
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> ((rspData == '0) && !rspAlignErr));

  // R8: no memory access during the response cycle
  a_r8_no_access_in_rsp: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !memEn);

  // R2: response returns the bridge to idle
  a_r2_ready_after_rsp: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> reqReady);

endmodule

bind halfword_fetch_bridge halfword_fetch_bridge_checker #(
  .ADDR_W (ADDR_W),
  .HALF_W (HALF_W)
) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqAddr     (reqAddr),
  .reqSize     (reqSize),
  .reqReady    (reqReady),
  .rspValid    (rspValid),
  .rspData     (rspData),
  .rspAlignErr (rspAlignErr),
  .memEn       (memEn),
  .memAddr     (memAddr)
);

// File: tb/halfword_fetch_bridge_bench.sv
`timescale 1ns/1ps
module halfword_fetch_bridge_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        reqReady, rspValid, rspAlignErr, memEn;
  logic [31:0] rspData;
  logic [14:0] memAddr;
  logic [15:0] memRdata = '0;

  int checks = 0;
  int errors = 0;
  int accCnt = 0;

  always #10 clk = ~clk;

  halfword_fetch_bridge u_halfword_fetch_bridge (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqReady(reqReady), .rspValid(rspValid),
    .rspData(rspData), .rspAlignErr(rspAlignErr), .memEn(memEn),
    .memAddr(memAddr), .memRdata(memRdata)
  );

  function automatic logic [15:0] memModel(input logic [14:0] a);
    return {a[6:0], a[14:6]} ^ 16'hA5C3;
  endfunction

  // synchronous-read memory and access counter
  always @(posedge clk) begin
    if (memEn) begin
      memRdata <= memModel(memAddr);
      accCnt   <= accCnt + 1;
    end
  end

  function automatic logic [31:0] expData(input logic [15:0] a, input logic [1:0] sz);
    logic [15:0] h;
    h = memModel(a[15:1]);
    if (sz[1]) begin
      if (a[1:0] != 2'b00) return 32'h0;
      return {memModel({a[15:2], 1'b1}), memModel({a[15:2], 1'b0})};
    end
    if (sz == 2'd1) return {16'h0, h};
    return a[0] ? {24'h0, h[15:8]} : {24'h0, h[7:0]};
  endfunction

  function automatic int expLat(input logic [15:0] a, input logic [1:0] sz);
    if (sz[1]) return (a[1:0] != 2'b00) ? 1 : 3;
    return 2;
  endfunction

  function automatic int expAcc(input logic [15:0] a, input logic [1:0] sz);
    if (sz[1]) return (a[1:0] != 2'b00) ? 0 : 2;
    return 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string reqTag(input logic [15:0] a, input logic [1:0] sz);
    if (sz[1]) return (a[1:0] != 2'b00) ? "R6" : "R3";
    if (sz == 2'd1) return "R4";
    return "R5";
  endfunction

  task automatic doRead(input logic [15:0] a, input logic [1:0] sz, input bit scramble);
    int cycles, startAcc;
    bit got, busyOk;
    logic [31:0] ed;
    string tag;
    tag = reqTag(a, sz);
    ed  = expData(a, sz);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqSize = sz;
    startAcc = accCnt; cycles = 0; got = 0; busyOk = 1;
    while (!got && cycles < 10) begin
      @(negedge clk);
      cycles++;
      if (rspValid) got = 1;
      else if (reqReady) busyOk = 0;
      if (scramble && cycles == 1) begin
        reqAddr = 16'($urandom);
        reqSize = 2'($urandom);
      end
    end
    check(got && rspData == ed, scramble ? "R9" : tag, "data", rspData, ed);
    check(rspAlignErr == (sz[1] && a[1:0] != 2'b00), (tag == "R6") ? "R6" : "R7", "alignErr",
          32'(rspAlignErr), 32'(sz[1] && a[1:0] != 2'b00));
    check(cycles == expLat(a, sz), tag, "latency", cycles, expLat(a, sz));
    check(accCnt - startAcc == expAcc(a, sz), "R8", "access count",
          accCnt - startAcc, expAcc(a, sz));
    check(busyOk, "R2", "ready while busy", 32'(busyOk), 32'd1);
    reqValid = 1'b0;
    @(negedge clk);
    check(!rspValid && reqReady && rspData == 0 && !rspAlignErr && accCnt - startAcc == expAcc(a, sz),
          "R7", "after response", {rspValid, reqReady, rspAlignErr, 29'(rspData)}, 32'h4000_0000);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(reqReady && !rspValid && !rspAlignErr && !memEn && rspData == 0, "R1", "in reset",
          {reqReady, rspValid, rspAlignErr, memEn, 28'(rspData)}, 32'h8000_0000);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !rspValid && !rspAlignErr && !memEn && rspData == 0, "R1", "after reset",
          {reqReady, rspValid, rspAlignErr, memEn, 28'(rspData)}, 32'h8000_0000);

    // directed corners
    doRead(16'h0000, 2'd2, 1'b0);   // R3 lowest word
    doRead(16'hFFFC, 2'd2, 1'b0);   // R3 highest word
    doRead(16'h1234, 2'd3, 1'b0);   // R3 size code 3
    doRead(16'h0001, 2'd1, 1'b0);   // R4 bit 0 ignored
    doRead(16'h8000, 2'd1, 1'b0);   // R4
    doRead(16'hFFFF, 2'd0, 1'b0);   // R5 upper lane
    doRead(16'h4242, 2'd0, 1'b0);   // R5 lower lane
    doRead(16'h0002, 2'd2, 1'b0);   // R6
    doRead(16'h0003, 2'd3, 1'b0);   // R6
    doRead(16'h2468, 2'd2, 1'b1);   // R9 word, inputs changed
    doRead(16'h1357, 2'd0, 1'b1);   // R9 byte, inputs changed

    // constrained random
    for (int i = 0; i < 150; i++) begin
      logic [15:0] a;
      logic [1:0]  s;
      a = 16'($urandom);
      s = 2'($urandom);
      if (s[1] && ($urandom % 4 != 0)) a[1:0] = 2'b00;
      doRead(a, s, ($urandom % 4) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule